// File: doc/BRIEF.md
# Frame Sequence Continuity Checker

This block watches a beat-oriented frame stream on its way into buffering and reports, per frame, whether the frame arrived in sequence and whether its payload check word is intact. Each frame opens with a start beat carrying a small stream number and a frame number that the source increments by one per frame. For every stream the block remembers the last accepted frame number, and it sorts each new frame into first-seen, in-order, duplicate, gap or out-of-order. The final beat of each frame carries a CRC over the frame's earlier beats, which the block recomputes and compares.

The stream itself passes through unchanged, one register stage later. On the output's end-of-frame beat a small flag word reports the frame's verdict so the flags travel with the frame. Four saturating counters (frames missing, duplicates, out-of-order frames, CRC failures) are driven continuously as outputs. The block never drops, alters or reorders a beat; it only observes and reports.

Top module: `fcc_seq_checker`

## Requirements
- R1: Every input beat appears on the output exactly one clock later with the same valid, start, end and data values; with no valid input the output valid is low.
- R2: The first frame of a stream after reset sets only flag bit 0 (first), loads that stream's last-accepted number from the frame, and changes no counter.
- R3: A frame whose number equals last+1 modulo 2^FW, including the step from all-ones to zero, raises no flag and becomes the new last-accepted number.
- R4: A frame whose number equals the last-accepted number sets flag bit 2 (duplicate), adds one to the duplicate counter and leaves the last-accepted number unchanged.
- R5: A frame whose modulo difference d from the last-accepted number satisfies 2 <= d < 2^(FW-1) sets flag bit 1 (gap), adds d-1 to the missing-frame counter and becomes the new last-accepted number.
- R6: A frame whose modulo difference is 2^(FW-1) or more sets flag bit 3 (out-of-order), adds one to the out-of-order counter and leaves the last-accepted number unchanged.
- R7: Each of the 2^SID_W streams keeps its own last-accepted number and first-seen state; frames of one stream never change another stream's classification.
- R8: The CRC (width CW, polynomial CRC_POLY, initial value all ones, data MSB first, no reflection, no final inversion) runs over every beat from the start beat up to but excluding the end beat; the end beat's low CW data bits are the check word. A mismatch sets flag bit 4 (crc_bad) and adds one to the CRC counter; a single-beat frame is compared against the initial value.
- R9: The flag word is non-zero only on an output end-of-frame beat; bits 0 to 3 are mutually exclusive and bit 4 may combine with any of them.
- R10: Every counter saturates at all ones and never wraps or decreases.
- R11: After reset all outputs and counters are zero and every stream is unlearned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Input beat is the frame's first beat |
| in_eof | input | 1 | Input beat is the frame's last beat (check word) |
| in_sid | input | SID_W | Stream number, sampled on the first beat |
| in_fid | input | FW | Frame number, sampled on the first beat |
| in_data | input | DW | Beat data |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output first beat |
| out_eof | output | 1 | Output last beat |
| out_data | output | DW | Output beat data |
| out_flags | output | 5 | Frame verdict: 0 first, 1 gap, 2 duplicate, 3 out-of-order, 4 crc_bad |
| cnt_drop | output | CNT_W | Saturating count of missing frames |
| cnt_dup | output | CNT_W | Saturating count of duplicate frames |
| cnt_ooo | output | CNT_W | Saturating count of out-of-order frames |
| cnt_crc | output | CNT_W | Saturating count of CRC failures |

## Verification
The bound checker watches every cycle for the one-cycle pass-through of valid and data, for flags appearing only on end beats with at most one sequence category set, and for counters that only move at the right beat, never decrease and step the duplicate, out-of-order and CRC counts by one. Whether a given frame number is classified correctly, how many frames a gap adds, that the wrap to zero is in order, that streams stay independent, that the CRC value matches, and where counters saturate can only be shown by the bench's scenarios against its behavioural model.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  // Per-frame verdict, bit 0 = first .. bit 4 = crc_bad
  typedef struct packed {
    logic crc_bad;
    logic ooo;
    logic dup;
    logic gap;
    logic first;
  } fcc_flags_t;
endpackage

// File: rtl/fcc_sat_cnt.sv
module fcc_sat_cnt #(
  parameter int W  = 16,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt
);
  localparam int SW = ((W > IW) ? W : IW) + 1;

  logic [SW-1:0] sum;
  logic [W-1:0]  cnt_d;

  always_comb begin
    sum   = SW'(cnt) + SW'(inc);
    cnt_d = (sum > SW'({W{1'b1}})) ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (inc_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/fcc_crc_acc.sv
module fcc_crc_acc #(
  parameter int             DW   = 16,
  parameter int             CW   = 16,
  parameter logic [CW-1:0]  POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_en,
  input  logic          sof,
  input  logic          eof,
  input  logic [DW-1:0] data,
  output logic          crc_bad
);
  localparam logic [CW-1:0] INIT = {CW{1'b1}};

  function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c, input logic [DW-1:0] d);
    logic [CW-1:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      if (r[CW-1] ^ d[i]) r = (r << 1) ^ POLY;
      else                r = r << 1;
    end
    return r;
  endfunction

  logic [CW-1:0] crc_q, base, crc_d;
  logic          acc_en;

  always_comb begin
    base    = sof ? INIT : crc_q;
    crc_d   = crc_step(base, data);
    acc_en  = beat_en && !eof;
    crc_bad = beat_en && eof && (data[CW-1:0] != base);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (acc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/fcc_seq_track.sv
module fcc_seq_track #(
  parameter int FW    = 16,
  parameter int SID_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_en,
  input  logic [SID_W-1:0]    sid,
  input  logic [FW-1:0]       fid,
  output fcc_pkg::fcc_flags_t cls,
  output logic [FW-1:0]       missing
);
  localparam int NS = 1 << SID_W;

  logic [NS-1:0] seen_v;
  logic [FW-1:0] last_v [NS];
  logic [FW-1:0] diff;
  logic          adv;

  // Classification of the incoming header against the stream's record
  always_comb begin
    diff    = fid - last_v[sid];
    cls     = '0;
    missing = '0;
    adv     = 1'b0;
    if (!seen_v[sid]) begin
      cls.first = 1'b1;
      adv       = 1'b1;
    end else if (diff == '0) begin
      cls.dup = 1'b1;
    end else if (diff == FW'(1)) begin
      adv = 1'b1;
    end else if (!diff[FW-1]) begin
      cls.gap = 1'b1;
      missing = diff - FW'(1);
      adv     = 1'b1;
    end else begin
      cls.ooo = 1'b1;
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_stream
    logic          wr_en;
    logic          seen_r;
    logic [FW-1:0] last_r;

    assign wr_en = hdr_en && adv && (sid == SID_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_r <= 1'b0;
        last_r <= '0;
      end else if (wr_en) begin
        seen_r <= 1'b1;
        last_r <= fid;
      end
    end

    assign seen_v[s] = seen_r;
    assign last_v[s] = last_r;
  end
endmodule

// File: rtl/fcc_seq_checker.sv
module fcc_seq_checker #(
  parameter int            DW       = 16,
  parameter int            CW       = 16,
  parameter logic [CW-1:0] CRC_POLY = 16'h1021,
  parameter int            FW       = 16,
  parameter int            SID_W    = 2,
  parameter int            CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [SID_W-1:0] in_sid,
  input  logic [FW-1:0]    in_fid,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [DW-1:0]    out_data,
  output logic [4:0]       out_flags,
  output logic [CNT_W-1:0] cnt_drop,
  output logic [CNT_W-1:0] cnt_dup,
  output logic [CNT_W-1:0] cnt_ooo,
  output logic [CNT_W-1:0] cnt_crc
);
  import fcc_pkg::*;

  logic       hdr_en, end_en, crc_bad;
  fcc_flags_t cls, hold_q, frame_fl;
  logic [FW-1:0] missing;
  logic [4:0] flags_d;

  assign hdr_en = in_valid && in_sof;
  assign end_en = in_valid && in_eof;

  fcc_seq_track #(.FW(FW), .SID_W(SID_W)) u_track (
    .clk(clk), .rst_n(rst_n), .hdr_en(hdr_en), .sid(in_sid), .fid(in_fid),
    .cls(cls), .missing(missing)
  );

  fcc_crc_acc #(.DW(DW), .CW(CW), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .beat_en(in_valid), .sof(in_sof), .eof(in_eof),
    .data(in_data), .crc_bad(crc_bad)
  );

  always_comb begin
    frame_fl         = hdr_en ? cls : hold_q;
    frame_fl.crc_bad = crc_bad;
    flags_d          = end_en ? 5'(frame_fl) : 5'd0;
  end

  // Sequence verdict held from the start beat to the end beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (hdr_en) hold_q <= cls;
  end

  // Pass-through stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= hdr_en;
      out_eof   <= end_en;
      out_flags <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_data <= '0;
    else if (in_valid) out_data <= in_data;
  end

  fcc_sat_cnt #(.W(CNT_W), .IW(FW)) u_cnt_drop (
    .clk(clk), .rst_n(rst_n), .inc_en(hdr_en && cls.gap), .inc(missing), .cnt(cnt_drop)
  );
  fcc_sat_cnt #(.W(CNT_W), .IW(1)) u_cnt_dup (
    .clk(clk), .rst_n(rst_n), .inc_en(hdr_en && cls.dup), .inc(1'b1), .cnt(cnt_dup)
  );
  fcc_sat_cnt #(.W(CNT_W), .IW(1)) u_cnt_ooo (
    .clk(clk), .rst_n(rst_n), .inc_en(hdr_en && cls.ooo), .inc(1'b1), .cnt(cnt_ooo)
  );
  fcc_sat_cnt #(.W(CNT_W), .IW(1)) u_cnt_crc (
    .clk(clk), .rst_n(rst_n), .inc_en(crc_bad), .inc(1'b1), .cnt(cnt_crc)
  );
endmodule

// File: rtl/fcc_seq_checker_sva.sv
module fcc_seq_checker_sva #(
  parameter int DW    = 16,
  parameter int FW    = 16,
  parameter int SID_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [DW-1:0]    in_data,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic [DW-1:0]    out_data,
  input logic [4:0]       out_flags,
  input logic [CNT_W-1:0] cnt_drop,
  input logic [CNT_W-1:0] cnt_dup,
  input logic [CNT_W-1:0] cnt_ooo,
  input logic [CNT_W-1:0] cnt_crc
);
  p_pass_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_data == $past(in_data)));

  p_pass_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_flags_on_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_flags != 5'd0) |-> (out_valid && out_eof));

  p_seq_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_flags[3:0]));

  p_dup_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dup != $past(cnt_dup)) |-> (out_sof && cnt_dup == $past(cnt_dup) + 1'b1));

  p_ooo_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ooo != $past(cnt_ooo)) |-> (out_sof && cnt_ooo == $past(cnt_ooo) + 1'b1));

  p_drop_at_sof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_drop != $past(cnt_drop)) |-> out_sof);

  p_crc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_crc != $past(cnt_crc)) |-> (out_flags[4] && cnt_crc == $past(cnt_crc) + 1'b1));

  p_no_decrease_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_drop >= $past(cnt_drop)) && (cnt_dup >= $past(cnt_dup)) &&
    (cnt_ooo >= $past(cnt_ooo)) && (cnt_crc >= $past(cnt_crc)));
endmodule

bind fcc_seq_checker fcc_seq_checker_sva #(
  .DW(DW), .FW(FW), .SID_W(SID_W), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
  .out_flags(out_flags), .cnt_drop(cnt_drop), .cnt_dup(cnt_dup), .cnt_ooo(cnt_ooo),
  .cnt_crc(cnt_crc)
);

// File: tb/fcc_seq_checker_tb.sv
module fcc_seq_checker_tb;
  localparam int            DW    = 16;
  localparam int            CW    = 16;
  localparam logic [CW-1:0] POLY  = 16'h1021;
  localparam int            FW    = 8;
  localparam int            SID_W = 2;
  localparam int            CNT_W = 4;
  localparam int            CMAX  = (1 << CNT_W) - 1;
  localparam int            MOD   = 1 << FW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [SID_W-1:0] in_sid = '0;
  logic [FW-1:0]    in_fid = '0;
  logic [DW-1:0]    in_data = '0;
  logic out_valid, out_sof, out_eof;
  logic [DW-1:0] out_data;
  logic [4:0] out_flags;
  logic [CNT_W-1:0] cnt_drop, cnt_dup, cnt_ooo, cnt_crc;

  always #2 clk = ~clk;

  fcc_seq_checker #(.DW(DW), .CW(CW), .CRC_POLY(POLY), .FW(FW), .SID_W(SID_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_sid(in_sid), .in_fid(in_fid), .in_data(in_data), .out_valid(out_valid),
    .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data), .out_flags(out_flags),
    .cnt_drop(cnt_drop), .cnt_dup(cnt_dup), .cnt_ooo(cnt_ooo), .cnt_crc(cnt_crc)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [CW-1:0] crc_ref(input logic [DW-1:0] q[$]);
    logic [CW-1:0] c = '1;
    foreach (q[k]) begin
      for (int b = DW - 1; b >= 0; b--) begin
        bit top = c[CW-1] ^ q[k][b];
        c = c << 1;
        if (top) c = c ^ POLY;
      end
    end
    return c;
  endfunction

  // Behavioural reference model
  bit            m_seen [4];
  int            m_last [4];
  int            m_drop, m_dup, m_ooo, m_crc;
  int            m_hold, d, s;
  logic [DW-1:0] m_q[$];
  logic          e_valid, e_sof, e_eof;
  logic [DW-1:0] e_data;
  int            e_flags;

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_seen[k]) begin m_seen[k] = 0; m_last[k] = 0; end
      m_drop = 0; m_dup = 0; m_ooo = 0; m_crc = 0; m_hold = 0;
      e_valid = 0; e_sof = 0; e_eof = 0; e_data = '0; e_flags = 0;
      m_q.delete();
    end else begin
      e_valid = in_valid;
      e_sof   = in_valid && in_sof;
      e_eof   = in_valid && in_eof;
      e_flags = 0;
      if (in_valid) begin
        e_data = in_data;
        if (in_sof) begin
          m_q.delete();
          s = int'(in_sid);
          if (!m_seen[s]) begin
            m_hold = 1; m_seen[s] = 1; m_last[s] = int'(in_fid);
          end else begin
            d = ((int'(in_fid) - m_last[s]) % MOD + MOD) % MOD;
            if (d == 0) begin m_hold = 4; m_dup = sat(m_dup + 1); end
            else if (d == 1) begin m_hold = 0; m_last[s] = int'(in_fid); end
            else if (d < MOD / 2) begin
              m_hold = 2; m_drop = sat(m_drop + d - 1); m_last[s] = int'(in_fid);
            end else begin m_hold = 8; m_ooo = sat(m_ooo + 1); end
          end
        end
        if (in_eof) begin
          e_flags = m_hold;
          if (in_data[CW-1:0] != crc_ref(m_q)) begin
            e_flags = e_flags | 16; m_crc = sat(m_crc + 1);
          end
        end else begin
          m_q.push_back(in_data);
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 out_valid", 32'(out_valid), 32'(e_valid));
      check("R1 out_sof",   32'(out_sof),   32'(e_sof));
      check("R1 out_eof",   32'(out_eof),   32'(e_eof));
      check("R1 out_data",  32'(out_data),  32'(e_data));
      check("R9 out_flags", 32'(out_flags), 32'(e_flags));
      check("R5 cnt_drop",  32'(cnt_drop),  32'(m_drop));
      check("R4 cnt_dup",   32'(cnt_dup),   32'(m_dup));
      check("R6 cnt_ooo",   32'(cnt_ooo),   32'(m_ooo));
      check("R8 cnt_crc",   32'(cnt_crc),   32'(m_crc));
    end
  end

  task automatic send_frame(input int sid, input int fid, input int nb, input bit corrupt,
                            output logic [4:0] fl);
    logic [DW-1:0] q[$];
    logic [CW-1:0] c;
    for (int i = 0; i < nb; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == nb - 1);
      in_sid   = SID_W'(sid);
      in_fid   = FW'(fid);
      if (i < nb - 1) begin
        in_data = DW'(fid * 37 + i * 101 + sid * 7 + 3);
        q.push_back(in_data);
      end else begin
        c = crc_ref(q);
        in_data = corrupt ? (c ^ 16'h0100) : c;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    fl = out_flags;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] fl;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    check("R11 out_valid", 32'(out_valid), 0);
    check("R11 out_flags", 32'(out_flags), 0);
    check("R11 counters", {cnt_drop, cnt_dup, cnt_ooo, cnt_crc}, 0);

    send_frame(0, 10, 3, 0, fl); check("R2 first flag", 32'(fl), 1);
    check("R2 counters untouched", {cnt_drop, cnt_dup, cnt_ooo, cnt_crc}, 0);
    send_frame(0, 11, 2, 0, fl); check("R3 in order", 32'(fl), 0);
    send_frame(0, 11, 2, 0, fl); check("R4 dup flag", 32'(fl), 4);
    check("R4 dup count", 32'(cnt_dup), 1);
    send_frame(0, 15, 4, 0, fl); check("R5 gap flag", 32'(fl), 2);
    check("R5 missing count", 32'(cnt_drop), 3);
    send_frame(0, 13, 2, 0, fl); check("R6 ooo flag", 32'(fl), 8);
    check("R6 ooo count", 32'(cnt_ooo), 1);
    send_frame(0, 16, 2, 0, fl); check("R6 last kept", 32'(fl), 0);

    send_frame(1, 255, 2, 0, fl); check("R2 first s1", 32'(fl), 1);
    send_frame(1, 0, 3, 0, fl);   check("R3 wrap in order", 32'(fl), 0);

    send_frame(2, 5, 2, 0, fl);   check("R7 first s2", 32'(fl), 1);
    send_frame(3, 100, 2, 0, fl); check("R7 first s3", 32'(fl), 1);
    send_frame(2, 6, 2, 0, fl);   check("R7 s2 in order", 32'(fl), 0);
    send_frame(3, 101, 2, 0, fl); check("R7 s3 in order", 32'(fl), 0);
    send_frame(0, 17, 2, 0, fl);  check("R7 s0 in order", 32'(fl), 0);

    send_frame(2, 7, 3, 1, fl);   check("R8 crc bad", 32'(fl), 16);
    check("R8 crc count", 32'(cnt_crc), 1);
    send_frame(2, 8, 1, 0, fl);   check("R8 single beat ok", 32'(fl), 0);
    send_frame(2, 9, 1, 1, fl);   check("R8 single beat bad", 32'(fl), 16);
    send_frame(3, 110, 3, 1, fl); check("R8 gap plus crc", 32'(fl), 18);
    check("R5 missing after second gap", 32'(cnt_drop), 11);

    for (int k = 0; k < 20; k++) send_frame(0, 17, 2, 0, fl);
    check("R10 dup saturates", 32'(cnt_dup), CMAX);
    send_frame(1, 100, 2, 0, fl);
    check("R10 missing saturates", 32'(cnt_drop), CMAX);

    repeat (3) @(posedge clk);
    #1;
    check("R1 idle output", 32'(out_valid), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule